// File: doc/BRIEF.md
# Serial Channel Register File

This block is the host-facing control and status plane of a single serial channel. The channel sits in a larger multi-channel receiver/transmitter. A byte-wide host port reads and writes a pair of mode registers, a command register, a status register and a shared holding-register address. A read at the holding address takes a byte from the receive queue. A write at the same address sends a byte to the transmit side. The block tracks whether the receiver and the transmitter are enabled, holds received bytes in a short queue, and keeps a break flag. It also keeps a pointer that steps through the two mode registers.

Received characters and break events come in on a simple byte-in port. Transmitted characters leave on a byte-out port as single-cycle strobes. Three level indications go to a shared interrupt block: transmitter ready, receive data waiting, and break change. Baud timing, bit serialization and the block-level registers are outside this block. Accesses that decode to another channel or to a block-level register change nothing here.

The `rst_n` input is an asynchronous active-low reset whose release is expected to be synchronized upstream.

Top module: `uart_chan_regs`

## Requirements
- R1: After reset every readable register returns 0x00. The receiver and transmitter are disabled, the mode pointer selects the first mode register, the receive queue is empty, and all three indications and `tx_valid` are low.
- R2: The register offset is the 5-bit bus address with bit 0 inverted. Offset bit 4 selects the channel and must equal `CHAN_SEL`. Offsets 0x1/0x3/0x5/0x7 (bus addresses 0x00/0x02/0x04/0x06 for channel 0) select mode, status, command and holding. Any other address changes nothing and reads 0x00.
- R3: Command bit 2 turns the transmitter on, which sets status bits 2 (TX ready) and 3 (TX empty) and `irq_txrdy`. Command bit 3, or command code 3 in bits 7:4, clears all three.
- R4: Command bit 0 enables the receiver and bit 1 disables it. Disable wins when both are set in one write. Command code 2 disables the receiver, empties the queue and clears status bit 0 and `irq_rxrdy`.
- R5: Both mode registers share one address. An access uses the register the pointer selects. Any read or write there moves the pointer to the second register, where it stays until command code 1 returns it to the first.
- R6: The receive queue holds `RX_DEPTH` bytes (3 by default) in arrival order. Status bit 0 and `irq_rxrdy` are high while it is non-empty. Status bit 1 is high when it is full. A holding-register read returns the oldest byte and removes it. A push and a pop in the same cycle are both honoured.
- R7: A received byte or break byte is dropped while the receiver is disabled or the queue is full.
- R8: A break event sets status bit 7 and pushes 0x00 under the rules of R7. The next holding-register read that removes a byte while bit 7 is set clears bit 7 and raises `irq_brk`. Command code 5 clears `irq_brk`.
- R9: Command code 4 clears status bits 7:4. Codes 6 to 15 change nothing.
- R10: A holding-register write while TX ready is set appears on `tx_data` with `tx_valid` high for one cycle, in the cycle after the write. While TX ready is clear the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe; side effects take place at the clock edge |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational from the address while `bus_rd` is high |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Break event strobe |
| tx_valid | output | 1 | Transmit character strobe |
| tx_data | output | 8 | Transmit character |
| irq_txrdy | output | 1 | Transmitter ready indication |
| irq_rxrdy | output | 1 | Receive data waiting indication |
| irq_brk | output | 1 | Break change indication |

## Verification
The bench builds the block with `CHAN_SEL` = 0 and `RX_DEPTH` = 3. With those values, addresses aimed at the sibling channel and at the block-level registers become real decode misses that the bench can show are ignored. The small queue also means a handful of pushes reach the full boundary, where the fourth byte must be dropped. With the same settings the bench can order a break between ordinary data, clear it early with the error reset, and line up a simultaneous push and pop on a partly filled queue.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

  localparam int REG_ADDR_W = 5;
  localparam int BYTE_W     = 8;
  localparam int MODE_REGS  = 2;

  // status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMT = 3;
  localparam int ST_BRK   = 7;

  // command codes in bits 7:4 of the command register
  localparam logic [3:0] CC_PTR_RST = 4'd1;
  localparam logic [3:0] CC_RX_RST  = 4'd2;
  localparam logic [3:0] CC_TX_RST  = 4'd3;
  localparam logic [3:0] CC_ERR_RST = 4'd4;
  localparam logic [3:0] CC_BRK_RST = 4'd5;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_HOLD = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_rst;
    logic brk_rst;
  } cmd_act_t;

endpackage

// File: rtl/uart_chan_decode.sv
module uart_chan_decode
  import uart_chan_pkg::*;
#(
  parameter int CHAN_SEL = 0
) (
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wr,
  input  logic                  rd,
  output logic                  hit,
  output reg_sel_e              sel,
  output logic                  mode_wr,
  output logic                  mode_rd,
  output logic                  cmd_wr,
  output logic                  hold_wr,
  output logic                  hold_rd
);

  localparam logic CSEL = 1'(CHAN_SEL);

  logic [REG_ADDR_W-1:0] off;

  // byte lanes sit at odd offsets: flip the low address bit
  assign off = addr ^ REG_ADDR_W'(1);
  assign hit = (off[4] == CSEL) && !off[3] && off[0];
  assign sel = reg_sel_e'(off[2:1]);

  assign mode_wr = hit && wr && (sel == SEL_MODE);
  assign mode_rd = hit && rd && (sel == SEL_MODE);
  assign cmd_wr  = hit && wr && (sel == SEL_CMD);
  assign hold_wr = hit && wr && (sel == SEL_HOLD);
  assign hold_rd = hit && rd && (sel == SEL_HOLD);

endmodule

// File: rtl/uart_chan_cmd.sv
module uart_chan_cmd
  import uart_chan_pkg::*;
(
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output cmd_act_t          act
);

  always_comb begin
    act = '0;
    if (wr) begin
      act.rx_on  = wdata[0];
      act.rx_off = wdata[1];
      act.tx_on  = wdata[2];
      act.tx_off = wdata[3];
      case (wdata[7:4])
        CC_PTR_RST: act.ptr_rst = 1'b1;
        CC_RX_RST:  act.rx_rst  = 1'b1;
        CC_TX_RST:  act.tx_rst  = 1'b1;
        CC_ERR_RST: act.err_rst = 1'b1;
        CC_BRK_RST: act.brk_rst = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/uart_chan_rxfifo.sv
module uart_chan_rxfifo #(
  parameter int DEPTH = 3,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = push && !full && !flush;
  assign rd_ok = pop && !empty && !flush;
  assign dout  = mem_q[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_ok) wr_d = ptr_inc(wr_q);
      if (rd_ok) rd_d = ptr_inc(rd_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (wr_ok && (wr_q == PTR_W'(g))) begin
        mem_q[g] <= din;
      end
    end
  end

endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uart_chan_pkg::*;
#(
  parameter int CHAN_SEL = 0,
  parameter int RX_DEPTH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  input  logic                  rx_valid,
  input  logic [BYTE_W-1:0]     rx_data,
  input  logic                  rx_break,
  output logic                  tx_valid,
  output logic [BYTE_W-1:0]     tx_data,
  output logic                  irq_txrdy,
  output logic                  irq_rxrdy,
  output logic                  irq_brk
);

  localparam int MPTR_W = $clog2(MODE_REGS);

  logic        hit;
  reg_sel_e    sel;
  logic        mode_wr, mode_rd, cmd_wr, hold_wr, hold_rd;
  cmd_act_t    act;

  logic [BYTE_W-1:0] mr_q [MODE_REGS];
  logic [MPTR_W-1:0] ptr_q, ptr_d;
  logic              rx_en_q, rx_en_d;
  logic              tx_on_q, tx_on_d;
  logic              brk_q, brk_d;
  logic              ibrk_q, ibrk_d;
  logic              txv_q, txv_d;
  logic [BYTE_W-1:0] txd_q;

  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [BYTE_W-1:0] fifo_din, fifo_dout;
  logic [BYTE_W-1:0] status;

  uart_chan_decode #(.CHAN_SEL(CHAN_SEL)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .hit     (hit),
    .sel     (sel),
    .mode_wr (mode_wr),
    .mode_rd (mode_rd),
    .cmd_wr  (cmd_wr),
    .hold_wr (hold_wr),
    .hold_rd (hold_rd)
  );

  uart_chan_cmd u_cmd (
    .wr    (cmd_wr),
    .wdata (bus_wdata),
    .act   (act)
  );

  // a break delivers a NUL character through the normal receive path
  assign fifo_push = (rx_valid || rx_break) && rx_en_q;
  assign fifo_din  = rx_break ? '0 : rx_data;
  assign fifo_pop  = hold_rd;

  uart_chan_rxfifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   (fifo_din),
    .pop   (fifo_pop),
    .flush (act.rx_rst),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  always_comb begin
    status           = '0;
    status[ST_RXRDY] = !fifo_empty;
    status[ST_FULL]  = fifo_full;
    status[ST_TXRDY] = tx_on_q;
    status[ST_TXEMT] = tx_on_q;
    status[ST_BRK]   = brk_q;
  end

  always_comb begin
    rx_en_d = rx_en_q;
    if (act.rx_on)                 rx_en_d = 1'b1;
    if (act.rx_off || act.rx_rst)  rx_en_d = 1'b0;

    tx_on_d = tx_on_q;
    if (act.tx_on)                 tx_on_d = 1'b1;
    if (act.tx_off || act.tx_rst)  tx_on_d = 1'b0;

    ptr_d = ptr_q;
    if (mode_wr || mode_rd)        ptr_d = MPTR_W'(MODE_REGS - 1);
    if (act.ptr_rst)               ptr_d = '0;

    brk_d = brk_q;
    if (rx_break)                  brk_d = 1'b1;
    if (fifo_pop && !fifo_empty && brk_q) brk_d = 1'b0;
    if (act.err_rst)               brk_d = 1'b0;

    ibrk_d = ibrk_q;
    if (fifo_pop && !fifo_empty && brk_q) ibrk_d = 1'b1;
    if (act.brk_rst)               ibrk_d = 1'b0;

    txv_d = hold_wr && tx_on_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      tx_on_q <= 1'b0;
      ptr_q   <= '0;
      brk_q   <= 1'b0;
      ibrk_q  <= 1'b0;
      txv_q   <= 1'b0;
    end else begin
      rx_en_q <= rx_en_d;
      tx_on_q <= tx_on_d;
      ptr_q   <= ptr_d;
      brk_q   <= brk_d;
      ibrk_q  <= ibrk_d;
      txv_q   <= txv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= '0;
    end else if (txv_d) begin
      txd_q <= bus_wdata;
    end
  end

  for (genvar m = 0; m < MODE_REGS; m++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mr_q[m] <= '0;
      end else if (mode_wr && (ptr_q == MPTR_W'(m))) begin
        mr_q[m] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit && bus_rd) begin
      case (sel)
        SEL_MODE: bus_rdata = mr_q[ptr_q];
        SEL_STAT: bus_rdata = status;
        SEL_HOLD: bus_rdata = fifo_dout;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign tx_valid  = txv_q;
  assign tx_data   = txd_q;
  assign irq_txrdy = tx_on_q;
  assign irq_rxrdy = !fifo_empty;
  assign irq_brk   = ibrk_q;

endmodule

// File: rtl/uart_chan_regs_chk.sv
module uart_chan_regs_chk #(
  parameter int CHAN_SEL = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       irq_txrdy,
  input logic       irq_rxrdy,
  input logic       irq_brk
);

  localparam logic       CSEL      = 1'(CHAN_SEL);
  localparam logic [4:0] CMD_ADDR  = {CSEL, 4'h4};
  localparam logic [4:0] HOLD_ADDR = {CSEL, 4'h6};

  logic cmd_w, hold_r, hold_w;
  assign cmd_w  = bus_wr && (bus_addr == CMD_ADDR);
  assign hold_r = bus_rd && (bus_addr == HOLD_ADDR);
  assign hold_w = bus_wr && (bus_addr == HOLD_ADDR);

  // R3: reset-TX command drops the ready indication
  p_txrst_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[7:4] == 4'd3) |=> !irq_txrdy);

  // R10: a transmit strobe only follows a holding write while ready
  p_tx_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(hold_w) && $past(irq_txrdy)));

  // R10: transmitted byte is the written byte
  p_tx_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == $past(bus_wdata)));

  // R6: receive-waiting drops only after a holding read or a command write
  p_rxrdy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_rxrdy) |-> ($past(hold_r) || $past(cmd_w)));

  // R8: break change rises only on a holding read
  p_brk_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_brk) |-> $past(hold_r));

  // R8: break-change reset command clears the indication
  p_brk_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && bus_wdata[7:4] == 4'd5) |=> !irq_brk);

endmodule

bind uart_chan_regs uart_chan_regs_chk #(.CHAN_SEL(CHAN_SEL)) u_chk (.*);

// File: tb/uart_chan_regs_tb.sv
module uart_chan_regs_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rx_valid, rx_break;
  logic [7:0] rx_data;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       irq_txrdy, irq_rxrdy, irq_brk;

  int checks = 0;
  int fails  = 0;
  logic [8:0] tx_seen;

  always #2.5 clk = ~clk;

  uart_chan_regs #(.CHAN_SEL(0), .RX_DEPTH(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq_txrdy(irq_txrdy),
    .irq_rxrdy(irq_rxrdy), .irq_brk(irq_brk)
  );

  localparam logic [2:0] OP_WR  = 3'd0;
  localparam logic [2:0] OP_RD  = 3'd1;
  localparam logic [2:0] OP_RX  = 3'd2;
  localparam logic [2:0] OP_BRK = 3'd3;
  localparam logic [2:0] OP_TX  = 3'd4;
  localparam logic [2:0] OP_IRQ = 3'd5;

  localparam logic [7:0] A_MR = 8'h00;
  localparam logic [7:0] A_SR = 8'h02;
  localparam logic [7:0] A_CR = 8'h04;
  localparam logic [7:0] A_HR = 8'h06;

  // {op, requirement, address, data, expected}; IRQ expected = {txrdy, rxrdy, brk}
  localparam int NV = 63;
  localparam logic [31:0] VEC [NV] = '{
    {OP_RD,  4'd1,  A_SR,  8'h00, 9'h000},  // R1
    {OP_IRQ, 4'd1,  A_SR,  8'h00, 9'h000},  // R1
    {OP_RD,  4'd5,  A_MR,  8'h00, 9'h000},  // R5 first mode reg
    {OP_WR,  4'd5,  A_MR,  8'h55, 9'h000},
    {OP_WR,  4'd5,  A_CR,  8'h10, 9'h000},
    {OP_WR,  4'd5,  A_MR,  8'h33, 9'h000},
    {OP_RD,  4'd5,  A_MR,  8'h00, 9'h055},  // R5 pointer moved
    {OP_RD,  4'd5,  A_MR,  8'h00, 9'h055},  // R5 sticky
    {OP_WR,  4'd5,  A_CR,  8'h10, 9'h000},
    {OP_RD,  4'd5,  A_MR,  8'h00, 9'h033},  // R5 pointer reset
    {OP_RX,  4'd7,  A_MR,  8'hA1, 9'h000},
    {OP_RD,  4'd7,  A_SR,  8'h00, 9'h000},  // R7 disabled receiver
    {OP_WR,  4'd6,  A_CR,  8'h01, 9'h000},
    {OP_RX,  4'd6,  A_MR,  8'hA1, 9'h000},
    {OP_RX,  4'd6,  A_MR,  8'hB2, 9'h000},
    {OP_RX,  4'd6,  A_MR,  8'hC3, 9'h000},
    {OP_RX,  4'd7,  A_MR,  8'hD4, 9'h000},
    {OP_RD,  4'd6,  A_SR,  8'h00, 9'h003},  // R6 full
    {OP_IRQ, 4'd6,  A_SR,  8'h00, 9'h002},
    {OP_RD,  4'd6,  A_HR,  8'h00, 9'h0A1},
    {OP_RD,  4'd6,  A_SR,  8'h00, 9'h001},
    {OP_RD,  4'd6,  A_HR,  8'h00, 9'h0B2},
    {OP_RD,  4'd6,  A_HR,  8'h00, 9'h0C3},
    {OP_RD,  4'd7,  A_SR,  8'h00, 9'h000},  // R7 fourth byte dropped
    {OP_IRQ, 4'd6,  A_SR,  8'h00, 9'h000},
    {OP_WR,  4'd3,  A_CR,  8'h04, 9'h000},
    {OP_RD,  4'd3,  A_SR,  8'h00, 9'h00C},  // R3
    {OP_IRQ, 4'd3,  A_SR,  8'h00, 9'h004},
    {OP_TX,  4'd10, A_HR,  8'h5A, 9'h15A},  // R10 forwarded
    {OP_WR,  4'd3,  A_CR,  8'h08, 9'h000},
    {OP_RD,  4'd3,  A_SR,  8'h00, 9'h000},
    {OP_IRQ, 4'd3,  A_SR,  8'h00, 9'h000},
    {OP_TX,  4'd10, A_HR,  8'h77, 9'h000},  // R10 dropped
    {OP_WR,  4'd3,  A_CR,  8'h04, 9'h000},
    {OP_WR,  4'd3,  A_CR,  8'h30, 9'h000},
    {OP_RD,  4'd3,  A_SR,  8'h00, 9'h000},  // R3 reset-TX
    {OP_WR,  4'd2,  8'h14, 8'h04, 9'h000},
    {OP_RD,  4'd2,  A_SR,  8'h00, 9'h000},  // R2 other channel
    {OP_RD,  4'd2,  8'h12, 8'h00, 9'h000},
    {OP_WR,  4'd2,  8'h0A, 8'hFF, 9'h000},
    {OP_WR,  4'd2,  8'h08, 8'hFF, 9'h000},
    {OP_WR,  4'd2,  8'h1A, 8'hFF, 9'h000},
    {OP_WR,  4'd2,  8'h01, 8'hEE, 9'h000},
    {OP_RD,  4'd2,  A_SR,  8'h00, 9'h000},
    {OP_RD,  4'd2,  A_MR,  8'h00, 9'h055},
    {OP_BRK, 4'd8,  A_MR,  8'h00, 9'h000},
    {OP_RD,  4'd8,  A_SR,  8'h00, 9'h081},  // R8 flag and NUL
    {OP_RD,  4'd8,  A_HR,  8'h00, 9'h000},
    {OP_RD,  4'd8,  A_SR,  8'h00, 9'h000},
    {OP_IRQ, 4'd8,  A_SR,  8'h00, 9'h001},
    {OP_WR,  4'd8,  A_CR,  8'h50, 9'h000},
    {OP_IRQ, 4'd8,  A_SR,  8'h00, 9'h000},
    {OP_BRK, 4'd9,  A_MR,  8'h00, 9'h000},
    {OP_RD,  4'd9,  A_SR,  8'h00, 9'h081},
    {OP_WR,  4'd9,  A_CR,  8'h40, 9'h000},
    {OP_RD,  4'd9,  A_SR,  8'h00, 9'h001},  // R9 error reset
    {OP_RD,  4'd9,  A_HR,  8'h00, 9'h000},
    {OP_IRQ, 4'd9,  A_SR,  8'h00, 9'h000},
    {OP_WR,  4'd9,  A_CR,  8'h04, 9'h000},
    {OP_WR,  4'd9,  A_CR,  8'hE0, 9'h000},
    {OP_WR,  4'd9,  A_CR,  8'h60, 9'h000},
    {OP_RD,  4'd9,  A_SR,  8'h00, 9'h00C},  // R9 unused codes
    {OP_WR,  4'd9,  A_CR,  8'h08, 9'h000}
  };

  task automatic chk(input int req, input logic [8:0] act, input logic [8:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[4:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    tx_seen = tx_valid ? {1'b1, tx_data} : 9'h000;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a[4:0];
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, {1'b0, v}, {1'b0, exp}, "read");
  endtask

  task automatic rx_byte(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rx_brk();
    @(negedge clk);
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic irq_chk(input int req, input logic [2:0] exp);
    @(negedge clk);
    #1 chk(req, {6'd0, irq_txrdy, irq_rxrdy, irq_brk}, {6'd0, exp}, "irq");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_break = 1'b0; tx_seen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      int         rq;
      logic [7:0] ad, dt;
      logic [8:0] ex;
      op = VEC[i][31:29];
      rq = int'(VEC[i][28:25]);
      ad = VEC[i][24:17];
      dt = VEC[i][16:9];
      ex = VEC[i][8:0];
      case (op)
        OP_WR:  wr(ad, dt);
        OP_RD:  begin rd(ad, v); chk(rq, {1'b0, v}, ex, "table read"); end
        OP_RX:  rx_byte(dt);
        OP_BRK: rx_brk();
        OP_TX:  begin wr(ad, dt); chk(rq, tx_seen, ex, "transmit"); end
        default: irq_chk(rq, ex[2:0]);
      endcase
    end

    // R4: reset-RX command empties and disables
    rx_byte(8'h11);
    rd_chk(4, A_SR, 8'h01);
    wr(A_CR, 8'h20);
    rd_chk(4, A_SR, 8'h00);
    irq_chk(4, 3'b000);
    rx_byte(8'h22);
    rd_chk(4, A_SR, 8'h00);
    // R4: disable bit, then both bits in one write
    wr(A_CR, 8'h01);
    rx_byte(8'h33);
    wr(A_CR, 8'h02);
    rx_byte(8'h44);
    rd_chk(4, A_SR, 8'h01);
    rd_chk(4, A_HR, 8'h33);
    wr(A_CR, 8'h03);
    rx_byte(8'h55);
    rd_chk(4, A_SR, 8'h00);

    // R6: push and pop in the same cycle
    wr(A_CR, 8'h01);
    rx_byte(8'h61);
    rx_byte(8'h62);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = A_HR[4:0]; rx_valid = 1'b1; rx_data = 8'h63;
    #1 chk(6, {1'b0, bus_rdata}, 9'h061, "concurrent pop");
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    rd_chk(6, A_SR, 8'h01);
    rd_chk(6, A_HR, 8'h62);
    rd_chk(6, A_HR, 8'h63);
    rd_chk(6, A_SR, 8'h00);

    // R1: reset in the middle of activity
    wr(A_CR, 8'h05);
    wr(A_MR, 8'hAA);
    rx_byte(8'h7E);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk(1, {6'd0, irq_txrdy, irq_rxrdy, irq_brk}, 9'h000, "irq in reset");
    chk(1, {8'd0, tx_valid}, 9'h000, "tx_valid in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_chk(1, A_SR, 8'h00);
    rd_chk(1, A_MR, 8'h00);
    rd_chk(1, A_MR, 8'h00);
    rx_byte(8'h12);
    rd_chk(1, A_SR, 8'h00);
    irq_chk(1, 3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule